// File: doc/BRIEF.md
# Dual-Channel Temperature Conversion Sequencer

This block decides when temperature measurements happen and turns raw readings into stored results. A conversion cycle always covers two channels: first the on-die (local) channel, then the external-diode (remote) channel. For each channel the block requests signed 8-bit raw readings from a measurement front end over a request/valid handshake. It accumulates sixteen of them and commits the floor of their mean. Both averages land in the value registers on the same clock edge. A one-cycle strobe tells the downstream limit comparator that fresh results are present.

Conversions repeat on their own at a rate chosen by a 3-bit code. The code selects the idle interval between one finished cycle and the next. That interval is a prescaled base tick multiplied by a power of two. Two standby sources stop the automatic schedule: an active-low standby pin and a software stop bit. Entering standby throws away a conversion that is in flight. Under the software stop bit alone, a one-shot write runs exactly one full cycle. The pin blocks everything, one-shots included. A busy flag covers every conversion. The remote open-circuit indicator is captured at the moment each conversion begins.

Top module: `tsq_conv_sequencer`

## Requirements
- R1: After reset, both value outputs read 0, the rate code reads 2, and busy, the sample request and the result strobe are all 0.
- R2: A rate write with data 0 to 7 loads the rate code. A write with data of 8 or more leaves the rate code unchanged. The current code is always visible on `rate_code`.
- R3: While the block is running (pin high, stop bit 0), the busy flag stays low for exactly PRESCALE × 2^(7 − code) clock cycles between the end of one conversion and the start of the next.
- R4: A conversion takes exactly 16 accepted samples with `smp_ch` = 0 (local) and then exactly 16 with `smp_ch` = 1 (remote). A sample is accepted only in a cycle where `smp_valid` and `smp_req` are both high.
- R5: Each committed value is the two's-complement 8-bit floor of (sum of the channel's 16 signed samples) / 16. Both values change on the same edge on which `results_stb` pulses high for one cycle, and at no other time.
- R6: `busy` is 1 from the edge that starts a conversion through the cycle before the commit edge. On the commit edge it falls as the strobe rises.
- R7: Taking the pin low, or setting the stop bit during an automatic conversion, ends the conversion within one cycle: busy falls, no strobe follows, and the values stay unchanged.
- R8: With the pin high and the stop bit 1, a one-shot write made while idle starts one conversion on the next edge. That conversion completes, commits once and leaves the block idle.
- R9: While the pin is low, a one-shot write has no effect: busy stays 0 and no result is committed.
- R10: `open_flag` takes the value of `open_in` on the edge that starts a conversion and holds it until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_n | input | 1 | Hardware standby pin, low = standby |
| cfg_stop | input | 1 | Software run/stop bit, 1 = standby |
| oneshot_wr | input | 1 | One-cycle pulse: write to the one-shot address |
| rate_wr | input | 1 | Rate register write strobe |
| rate_wdata | input | 8 | Rate register write data |
| rate_code | output | 3 | Current rate code |
| smp_req | output | 1 | Raw sample request to the front end |
| smp_ch | output | 1 | Channel being sampled, 0 = local, 1 = remote |
| smp_valid | input | 1 | Front end presents a raw sample |
| smp_data | input | 8 | Signed raw sample |
| open_in | input | 1 | Remote open-circuit comparator output |
| open_flag | output | 1 | Open-circuit state captured at conversion start |
| busy | output | 1 | Conversion in progress |
| local_val | output | 8 | Committed local average |
| remote_val | output | 8 | Committed remote average |
| results_stb | output | 1 | One-cycle pulse when both values update |

## Verification
The averaging path is fed five sample patterns. Full-range random readings check general summation. Constant −128 and constant +127 readings push the accumulator to its two signed extremes and would expose a narrow or unsigned sum. Alternating −128/+127 readings give a mean of −0.5, which separates floor from truncation toward zero. Runs of −1 and 0 probe rounding just below zero. The idle interval is measured at rate codes 7, 5 and 0, which tells a correct power-of-two divider from an off-by-one or reversed code. Aborts are triggered from each standby source separately. One-shots are tried with the pin both high and low.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LOCAL  = 2'd1,
    SEQ_REMOTE = 2'd2
  } seq_state_e;

  // Idle interval in base ticks for a rate code: fastest code gives one tick.
  function automatic int unsigned period_ticks(int unsigned code, int unsigned code_max);
    return 32'd1 << (code_max - code);
  endfunction

endpackage

// File: rtl/tsq_pacer.sv
module tsq_pacer #(
  parameter int unsigned PRESCALE = 1250000,
  parameter int unsigned RATE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate_code,
  output logic              fire
);
  localparam int unsigned PRE_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned TCNT_W   = 1 << RATE_W;
  localparam int unsigned CODE_MAX = (1 << RATE_W) - 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [TCNT_W-1:0] div_last;
  logic              base_tick;

  always_comb begin
    div_last  = TCNT_W'(tsq_pkg::period_ticks(32'(rate_code), CODE_MAX) - 1);
    base_tick = enable && (pre_q == PRE_LAST);
    // >= keeps a faster code written mid-wait from wrapping the count
    fire      = base_tick && (tcnt_q >= div_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tcnt_q <= '0;
    end else if (!enable) begin
      pre_q  <= '0;
      tcnt_q <= '0;
    end else if (base_tick) begin
      pre_q  <= '0;
      tcnt_q <= fire ? '0 : tcnt_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  // R3
  fire_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((PRESCALE > 1) && fire) |-> $past(enable));

endmodule

// File: rtl/tsq_accum.sv
module tsq_accum #(
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned AVG_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [TEMP_W-1:0] din,
  output logic              last,
  output logic [TEMP_W-1:0] avg_next
);
  localparam int unsigned ACC_W = TEMP_W + AVG_LOG2;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nx;
  logic [AVG_LOG2-1:0]     cnt_q;

  function automatic logic [TEMP_W-1:0] fold_avg(logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] sh;
    sh = s >>> AVG_LOG2;
    return sh[TEMP_W-1:0];
  endfunction

  always_comb begin
    acc_nx   = acc_q + $signed({{AVG_LOG2{din[TEMP_W-1]}}, din});
    last     = take && (cnt_q == '1);
    avg_next = fold_avg(acc_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= last ? '0 : acc_nx;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  accum_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  accum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/tsq_conv_sequencer.sv
module tsq_conv_sequencer #(
  parameter int unsigned PRESCALE = 1250000,
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned AVG_LOG2 = 4,
  parameter int unsigned RATE_W   = 3,
  parameter logic [RATE_W-1:0] RATE_RST = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_n,
  input  logic              cfg_stop,
  input  logic              oneshot_wr,
  input  logic              rate_wr,
  input  logic [7:0]        rate_wdata,
  output logic [RATE_W-1:0] rate_code,
  output logic              smp_req,
  output logic              smp_ch,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_data,
  input  logic              open_in,
  output logic              open_flag,
  output logic              busy,
  output logic [TEMP_W-1:0] local_val,
  output logic [TEMP_W-1:0] remote_val,
  output logic              results_stb
);
  import tsq_pkg::*;

  localparam int unsigned CODE_MAX = (1 << RATE_W) - 1;

  seq_state_e        st_q;
  logic              os_run_q;
  logic [TEMP_W-1:0] loc_hold_q;
  logic [RATE_W-1:0] rate_q;

  // named internal events
  logic run_mode, conv_live, abort_ev, os_ev, auto_ev, start_ev, take_ev;
  logic acc_clr, acc_last;
  logic [TEMP_W-1:0] acc_avg;

  always_comb begin
    run_mode  = stby_n && !cfg_stop;
    conv_live = (st_q != SEQ_IDLE);
    abort_ev  = conv_live && (!stby_n || (cfg_stop && !os_run_q));
    os_ev     = oneshot_wr && stby_n && cfg_stop && !conv_live;
    take_ev   = smp_valid && conv_live && !abort_ev;
    acc_clr   = !conv_live || abort_ev;
    start_ev  = os_ev || auto_ev;
  end

  tsq_pacer #(.PRESCALE(PRESCALE), .RATE_W(RATE_W)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (run_mode && !conv_live),
    .rate_code (rate_q),
    .fire      (auto_ev)
  );

  tsq_accum #(.TEMP_W(TEMP_W), .AVG_LOG2(AVG_LOG2)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (acc_clr),
    .take     (take_ev),
    .din      (smp_data),
    .last     (acc_last),
    .avg_next (acc_avg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_RST;
    end else if (rate_wr && (32'(rate_wdata) <= CODE_MAX)) begin
      rate_q <= rate_wdata[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_IDLE;
      os_run_q    <= 1'b0;
      loc_hold_q  <= '0;
      local_val   <= '0;
      remote_val  <= '0;
      results_stb <= 1'b0;
      open_flag   <= 1'b0;
    end else begin
      results_stb <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (start_ev) begin
            st_q      <= SEQ_LOCAL;
            os_run_q  <= os_ev;
            open_flag <= open_in;
          end
        end
        SEQ_LOCAL: begin
          if (abort_ev) begin
            st_q <= SEQ_IDLE;
          end else if (acc_last) begin
            loc_hold_q <= acc_avg;
            st_q       <= SEQ_REMOTE;
          end
        end
        SEQ_REMOTE: begin
          if (abort_ev) begin
            st_q <= SEQ_IDLE;
          end else if (acc_last) begin
            local_val   <= loc_hold_q;
            remote_val  <= acc_avg;
            results_stb <= 1'b1;
            st_q        <= SEQ_IDLE;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    rate_code = rate_q;
    busy      = conv_live;
    smp_req   = conv_live;
    smp_ch    = (st_q == SEQ_REMOTE);
  end

  // R7
  pin_low_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> !busy);

  // R7
  abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (!results_stb && $stable(local_val) && $stable(remote_val)));

  // R5
  values_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !results_stb |-> ($stable(local_val) && $stable(remote_val)));

  // R6
  busy_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    results_stb |-> (!busy && $past(busy)));

  // R10
  open_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (open_flag == $past(open_in)));

  // R2
  rate_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_wr && (32'(rate_wdata) > CODE_MAX)) |=> $stable(rate_code));

  // R9
  oneshot_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_wr && !stby_n && !busy) |=> !busy);

endmodule

// File: tb/tsq_conv_sequencer_test.sv
`timescale 1ns/100ps
module tsq_conv_sequencer_test;
  localparam int PRE = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, stby_n, cfg_stop, oneshot_wr, rate_wr, open_in, smp_valid;
  logic [7:0] rate_wdata, smp_data;
  logic [2:0] rate_code;
  logic smp_req, smp_ch, open_flag, busy, results_stb;
  logic [7:0] local_val, remote_val;

  tsq_conv_sequencer #(.PRESCALE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .cfg_stop(cfg_stop),
    .oneshot_wr(oneshot_wr), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .rate_code(rate_code), .smp_req(smp_req), .smp_ch(smp_ch),
    .smp_valid(smp_valid), .smp_data(smp_data), .open_in(open_in),
    .open_flag(open_flag), .busy(busy), .local_val(local_val),
    .remote_val(remote_val), .results_stb(results_stb)
  );

  int vectors = 0, errors = 0;
  int stb_cnt = 0, busy_samples = 0;
  int pat = 0, rate_exp = 2;
  int loc_sum = 0, rem_sum = 0, loc_n = 0, rem_n = 0;
  bit gap_armed = 0, disarm = 0, prev_busy = 0;
  int gap = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sx8(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic int mean_floor(int s);
    int q = s / 16;
    if (s < 0 && (s % 16) != 0) q = q - 1;
    return q;
  endfunction

  function automatic logic [7:0] pick(int mode, int idx);
    case (mode)
      1: return 8'h80;
      2: return 8'h7F;
      3: return idx[0] ? 8'h80 : 8'h7F;
      4: return ($urandom_range(0, 1) == 1) ? 8'hFF : 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  // front end model
  initial begin
    forever begin
      @(negedge clk);
      if (!busy) begin
        loc_sum = 0; rem_sum = 0; loc_n = 0; rem_n = 0;
      end
      if (smp_req && $urandom_range(0, 2) != 0) begin
        logic [7:0] v;
        v = pick(pat, smp_ch ? rem_n : loc_n);
        smp_valid = 1'b1;
        smp_data  = v;
        if (smp_ch) begin rem_sum += sx8(v); rem_n++; end
        else begin loc_sum += sx8(v); loc_n++; end
      end else begin
        smp_valid = 1'b0;
      end
    end
  end

  // result and interval monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (busy) busy_samples++;
        if (results_stb) begin
          stb_cnt++;
          chk(loc_n == 16, "R4 local sample count", loc_n, 16);
          chk(rem_n == 16, "R4 remote sample count", rem_n, 16);
          chk(local_val == 8'(mean_floor(loc_sum)), "R5 local average",
              int'(local_val), int'(8'(mean_floor(loc_sum))));
          chk(remote_val == 8'(mean_floor(rem_sum)), "R5 remote average",
              int'(remote_val), int'(8'(mean_floor(rem_sum))));
          chk(prev_busy && !busy, "R6 busy across commit", int'(busy), 0);
          gap_armed = !disarm;
          gap = 1;
        end else if (gap_armed) begin
          if (!(stby_n && !cfg_stop) || disarm) gap_armed = 0;
          else if (!busy) gap++;
          else begin
            chk(gap == PRE * (1 << (7 - rate_exp)), "R3 idle interval",
                gap, PRE * (1 << (7 - rate_exp)));
            gap_armed = 0;
          end
        end
        disarm = 0;
        prev_busy = busy;
      end
    end
  end

  task automatic write_rate(logic [7:0] d);
    @(negedge clk);
    rate_wr = 1'b1; rate_wdata = d; disarm = 1;
    if (d < 8) rate_exp = int'(d);
    @(negedge clk);
    rate_wr = 1'b0;
    chk(rate_code == 3'(rate_exp), "R2 rate readback", int'(rate_code), rate_exp);
  endtask

  task automatic pulse_oneshot();
    @(negedge clk);
    oneshot_wr = 1'b1;
    @(negedge clk);
    oneshot_wr = 1'b0;
  endtask

  task automatic wait_stb(int n);
    int target = stb_cnt + n;
    int t = 0;
    while (stb_cnt < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(stb_cnt >= target, "R5 conversions completed", stb_cnt, target);
  endtask

  task automatic wait_busy();
    int t = 0;
    while (!busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] lv, rv;
    int s, bs;
    rst_n = 0; stby_n = 1; cfg_stop = 0; oneshot_wr = 0; rate_wr = 0;
    rate_wdata = 0; open_in = 0; smp_valid = 0; smp_data = 0;
    void'($urandom(32'h5EED_0101));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(local_val == 0, "R1 local reset", int'(local_val), 0);
    chk(remote_val == 0, "R1 remote reset", int'(remote_val), 0);
    chk(rate_code == 3'd2, "R1 rate reset", int'(rate_code), 2);
    chk(!busy && !smp_req, "R1 busy/req reset", int'(busy), 0);
    chk(!results_stb, "R1 strobe reset", int'(results_stb), 0);
    rst_n = 1;

    // R2 rate writes, reserved codes ignored
    write_rate(8'd7);
    write_rate(8'd9);
    write_rate(8'hF0);

    // R4/R5 sample patterns, R3 at code 7
    for (int p = 0; p < 5; p++) begin
      pat = p;
      wait_stb(3);
    end
    pat = 0;
    write_rate(8'd5); wait_stb(2);
    write_rate(8'd0); wait_stb(2);
    write_rate(8'd7); wait_stb(1);

    // R7 abort by stop bit
    wait_busy();
    repeat (10) @(negedge clk);
    lv = local_val; rv = remote_val; s = stb_cnt;
    cfg_stop = 1;
    @(negedge clk);
    chk(!busy, "R7 stop bit aborts", int'(busy), 0);
    repeat (100) @(negedge clk);
    chk(stb_cnt == s, "R7 no commit after stop", stb_cnt, s);
    chk(local_val == lv && remote_val == rv, "R7 values kept", int'(local_val), int'(lv));

    // R7 abort by pin
    cfg_stop = 0;
    wait_busy();
    repeat (10) @(negedge clk);
    lv = local_val; rv = remote_val; s = stb_cnt;
    stby_n = 0;
    @(negedge clk);
    chk(!busy, "R7 pin aborts", int'(busy), 0);

    // R9 one-shot ignored while pin low
    cfg_stop = 1;
    bs = busy_samples;
    pulse_oneshot();
    repeat (150) @(negedge clk);
    chk(busy_samples == bs, "R9 one-shot blocked", busy_samples, bs);
    chk(stb_cnt == s, "R9 no commit", stb_cnt, s);
    chk(local_val == lv && remote_val == rv, "R7 values kept after pin", int'(remote_val), int'(rv));

    // R8 one-shot in software standby, R10 open capture
    stby_n = 1;
    repeat (20) @(negedge clk);
    open_in = 1;
    s = stb_cnt;
    pulse_oneshot();
    chk(busy, "R8 one-shot starts", int'(busy), 1);
    chk(open_flag, "R10 open captured", int'(open_flag), 1);
    open_in = 0;
    repeat (300) @(negedge clk);
    chk(stb_cnt == s + 1, "R8 exactly one conversion", stb_cnt, s + 1);
    chk(!busy, "R8 back to standby", int'(busy), 0);
    chk(open_flag, "R10 open held", int'(open_flag), 1);

    s = stb_cnt;
    pulse_oneshot();
    chk(!open_flag, "R10 open recaptured", int'(open_flag), 0);
    repeat (300) @(negedge clk);
    chk(stb_cnt == s + 1, "R8 second one-shot", stb_cnt, s + 1);

    summary();
    $finish;
  end
endmodule